// File: doc/BRIEF.md
# Predicated Element Issue Sequencer

This block turns a single operation written against scalar register numbers into a run of element operations over a vector length. On a start pulse it captures the three base register numbers, a vector flag for each operand, the length, a predicate word, an invert flag and a zeroing flag. It then walks element indices upward and hands out register triples to an ALU that has a configurable number of lanes. In each cycle it fills lanes from lane 0 with the next pending elements.

A predicate bit set at position i enables element i. When zeroing is off, disabled elements are dropped and the enabled ones are compacted into the free lanes. As a result, the issue time depends only on how many elements are enabled. When zeroing is on, every element below the length is issued in order. Disabled elements carry a strobe that asks for a zero to be written to their destination.

A register number advances with the element index only for an operand flagged as a vector. A scalar operand always reads its base register. The ALU and the register file sit outside the block.

Top module: `pes_top`

## Requirements
- R1: A start pulse while idle is captured at the clock edge. Busy reads 1 from the following cycle, and the first issue group appears in that same cycle.
- R2: Element i (bit i of the predicate word, bit 0 being element 0) is enabled when that bit is 1 and i is below the length. A length above XLEN is treated as XLEN.
- R3: With zeroing off, only enabled elements are issued. They go out in increasing index order and are packed into lanes from lane 0 with no gaps. At most LANES elements go out per cycle.
- R4: With zeroing off, the operation takes ceil(enabled/LANES) issue cycles, and done is high in the cycle of the last group. With 6 of 8 elements enabled, four lanes issue 4 elements and then 2, and one lane takes 6 cycles.
- R5: With zeroing on, every element below the length is issued in order. A disabled element carries zero-write strobe 1, and an enabled element carries 0.
- R6: The lane destination is rd_base + i modulo 2^RW when rd_is_vec is 1, and rd_base otherwise. The same rule applies to rs1 and rs2. The offset follows the element index whether or not earlier elements were enabled.
- R7: With pred_inv set, every predicate bit is complemented before elements are selected.
- R8: A zero length, or a predicate with no enabled element in skip mode, gives done in the first cycle after start with no lane valid.
- R9: A start pulse while busy is ignored. Busy falls in the cycle after done, and no lane is valid while idle.
- R10: After reset, busy, done and all lane valids are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| vl | input | VLW | Vector length |
| pred_word | input | XLEN | Predicate mask, bit i for element i |
| pred_inv | input | 1 | Complement the predicate |
| zero_en | input | 1 | 1: zero masked elements, 0: skip them |
| rd_base | input | RW | Destination base register |
| rs1_base | input | RW | Source 1 base register |
| rs2_base | input | RW | Source 2 base register |
| rd_is_vec | input | 1 | Destination advances per element |
| rs1_is_vec | input | 1 | Source 1 advances per element |
| rs2_is_vec | input | 1 | Source 2 advances per element |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Current group is the last one |
| lane_valid | output | LANES | Lane carries an element |
| lane_zero | output | LANES | Lane's element writes zero |
| lane_rd | output | LANES*RW | Per-lane destination register |
| lane_rs1 | output | LANES*RW | Per-lane source 1 register |
| lane_rs2 | output | LANES*RW | Per-lane source 2 register |

## Verification
Start is sampled at a rising edge. Busy and the first lane group are then due in the next cycle, with no extra register stage. Each further group is due one cycle later, and done accompanies the last group. Busy is due low one cycle after done.

The bench drives inputs and samples outputs on falling edges. Its first sample after releasing start is therefore the first issue cycle. From there it steps one cycle per group, comparing each lane against an element list computed from the predicate, the length and the mode. It runs a four-lane and a one-lane instance side by side, so compaction and per-element issue are checked against the same stimulus.

// File: rtl/pes_pkg.sv
package pes_pkg;
    // positions of the operand vector flags in the captured flag field
    localparam int VF_RD  = 0;
    localparam int VF_RS1 = 1;
    localparam int VF_RS2 = 2;
    localparam int VF_W   = 3;
endpackage

// File: rtl/pes_sel_mask.sv
// Builds the enable mask (predicate after optional inversion, cut to the
// length) and the issue mask (all in-range elements when zeroing).
module pes_sel_mask #(
    parameter int XLEN = 16,
    parameter int VLW  = 5
) (
    input  logic [VLW-1:0]  vl,
    input  logic [XLEN-1:0] pred_word,
    input  logic            pred_inv,
    input  logic            zero_en,
    output logic [XLEN-1:0] en_mask,
    output logic [XLEN-1:0] issue_mask
);
    logic [XLEN-1:0] range_mask;
    logic [XLEN-1:0] pol_mask;

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            range_mask[i] = (32'(vl) > i);
        end
        pol_mask   = pred_inv ? ~pred_word : pred_word;
        en_mask    = pol_mask & range_mask;
        issue_mask = zero_en ? range_mask : en_mask;
    end
endmodule

// File: rtl/pes_pick.sv
// Takes the lowest set bit of a mask and returns the mask without it.
module pes_pick #(
    parameter int XLEN = 16,
    parameter int IW   = 4
) (
    input  logic [XLEN-1:0] mask_in,
    output logic            hit,
    output logic [IW-1:0]   elem,
    output logic [XLEN-1:0] mask_out
);
    always_comb begin
        hit      = 1'b0;
        elem     = '0;
        mask_out = mask_in;
        for (int i = 0; i < XLEN; i++) begin
            if (!hit && mask_in[i]) begin
                hit         = 1'b1;
                elem        = IW'(i);
                mask_out[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pes_map.sv
// Register number for one operand of one element.
module pes_map #(
    parameter int RW = 5,
    parameter int IW = 4
) (
    input  logic [RW-1:0] base,
    input  logic          is_vec,
    input  logic [IW-1:0] elem,
    output logic [RW-1:0] reg_num
);
    localparam int SW = (RW > IW) ? RW + 1 : IW + 1;
    logic [SW-1:0] sum;

    always_comb begin
        sum     = SW'(base) + (is_vec ? SW'(elem) : '0);
        reg_num = sum[RW-1:0];
    end
endmodule

// File: rtl/pes_top.sv
module pes_top #(
    parameter int XLEN  = 16,
    parameter int LANES = 4,
    parameter int RW    = 5,
    localparam int VLW  = $clog2(XLEN + 1),
    localparam int IW   = $clog2(XLEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VLW-1:0]      vl,
    input  logic [XLEN-1:0]     pred_word,
    input  logic                pred_inv,
    input  logic                zero_en,
    input  logic [RW-1:0]       rd_base,
    input  logic [RW-1:0]       rs1_base,
    input  logic [RW-1:0]       rs2_base,
    input  logic                rd_is_vec,
    input  logic                rs1_is_vec,
    input  logic                rs2_is_vec,
    output logic                busy,
    output logic                done,
    output logic [LANES-1:0]    lane_valid,
    output logic [LANES-1:0]    lane_zero,
    output logic [LANES*RW-1:0] lane_rd,
    output logic [LANES*RW-1:0] lane_rs1,
    output logic [LANES*RW-1:0] lane_rs2
);
    import pes_pkg::*;

    typedef struct packed {
        logic                busy;
        logic [XLEN-1:0]     pend;
        logic [XLEN-1:0]     en;
        logic                zm;
        logic [RW-1:0]       rd_b;
        logic [RW-1:0]       rs1_b;
        logic [RW-1:0]       rs2_b;
        logic [VF_W-1:0]     vflag;
    } seq_t;

    seq_t st_d, st_q;

    logic [XLEN-1:0] en_new;
    logic [XLEN-1:0] issue_new;

    pes_sel_mask #(.XLEN(XLEN), .VLW(VLW)) u_sel (
        .vl         (vl),
        .pred_word  (pred_word),
        .pred_inv   (pred_inv),
        .zero_en    (zero_en),
        .en_mask    (en_new),
        .issue_mask (issue_new)
    );

    // lane compaction chain: each lane removes the lowest pending element
    logic [XLEN-1:0] chain [LANES+1];
    logic [IW-1:0]   elem_k [LANES];
    logic [LANES-1:0] hit_k;

    assign chain[0] = st_q.pend;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [RW-1:0] rd_n, rs1_n, rs2_n;

        pes_pick #(.XLEN(XLEN), .IW(IW)) u_pick (
            .mask_in  (chain[k]),
            .hit      (hit_k[k]),
            .elem     (elem_k[k]),
            .mask_out (chain[k+1])
        );

        pes_map #(.RW(RW), .IW(IW)) u_map_rd (
            .base    (st_q.rd_b),
            .is_vec  (st_q.vflag[VF_RD]),
            .elem    (elem_k[k]),
            .reg_num (rd_n)
        );
        pes_map #(.RW(RW), .IW(IW)) u_map_rs1 (
            .base    (st_q.rs1_b),
            .is_vec  (st_q.vflag[VF_RS1]),
            .elem    (elem_k[k]),
            .reg_num (rs1_n)
        );
        pes_map #(.RW(RW), .IW(IW)) u_map_rs2 (
            .base    (st_q.rs2_b),
            .is_vec  (st_q.vflag[VF_RS2]),
            .elem    (elem_k[k]),
            .reg_num (rs2_n)
        );

        always_comb begin
            lane_valid[k]           = st_q.busy & hit_k[k];
            lane_zero[k]            = st_q.busy & hit_k[k] & st_q.zm & ~st_q.en[elem_k[k]];
            lane_rd [k*RW +: RW]    = rd_n;
            lane_rs1[k*RW +: RW]    = rs1_n;
            lane_rs2[k*RW +: RW]    = rs2_n;
        end
    end

    logic last_grp;
    assign last_grp = (chain[LANES] == '0);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.pend = chain[LANES];
            if (last_grp) begin
                st_d.busy = 1'b0;
            end
        end else if (start) begin
            st_d.busy              = 1'b1;
            st_d.pend              = issue_new;
            st_d.en                = en_new;
            st_d.zm                = zero_en;
            st_d.rd_b              = rd_base;
            st_d.rs1_b             = rs1_base;
            st_d.rs2_b             = rs2_base;
            st_d.vflag[VF_RD]      = rd_is_vec;
            st_d.vflag[VF_RS1]     = rs1_is_vec;
            st_d.vflag[VF_RS2]     = rs2_is_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.busy & last_grp;
endmodule

// File: rtl/pes_check.sv
module pes_check #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [LANES-1:0] lane_valid,
    input logic [LANES-1:0] lane_zero
);
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R1

    AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_valid & (lane_valid + LANES'(1))) == '0)); // R3

    AST_ZERO_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_zero & ~lane_valid) == '0)); // R5

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R4

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9

    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_valid == '0)); // R9
endmodule

bind pes_top pes_check #(.LANES(LANES)) u_pes_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .lane_valid (lane_valid),
    .lane_zero  (lane_zero)
);

// File: tb/pes_top_test.sv
`timescale 1ns/1ps
module pes_top_test;
    typedef struct packed {
        logic [4:0]  vl;
        logic [15:0] mask;
        logic        inv;
        logic        zm;
        logic [4:0]  rdb;
        logic [4:0]  r1b;
        logic [4:0]  r2b;
        logic [2:0]  vecs;   // {rs2, rs1, rd}
        logic [3:0]  cyc4;   // expected issue cycles on four lanes
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TABLE [NV] = '{
        '{5'd8,  16'h00DB, 1'b0, 1'b0, 5'd0,  5'd8,  5'd16, 3'b111, 4'd2},
        '{5'd8,  16'h00DB, 1'b0, 1'b1, 5'd2,  5'd10, 5'd20, 3'b111, 4'd2},
        '{5'd16, 16'hFFFF, 1'b1, 1'b0, 5'd1,  5'd2,  5'd3,  3'b111, 4'd1},
        '{5'd0,  16'hFFFF, 1'b0, 1'b0, 5'd1,  5'd2,  5'd3,  3'b111, 4'd1},
        '{5'd5,  16'h0F0F, 1'b0, 1'b0, 5'd4,  5'd9,  5'd12, 3'b001, 4'd1},
        '{5'd31, 16'h8001, 1'b1, 1'b0, 5'd30, 5'd5,  5'd7,  3'b011, 4'd4},
        '{5'd3,  16'h0000, 1'b0, 1'b1, 5'd6,  5'd0,  5'd0,  3'b101, 4'd1},
        '{5'd16, 16'hAAAA, 1'b0, 1'b0, 5'd16, 5'd17, 5'd18, 3'b110, 4'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [4:0]  vl = '0;
    logic [15:0] pred = '0;
    logic inv = 1'b0, zm = 1'b0;
    logic [4:0] rdb = '0, r1b = '0, r2b = '0;
    logic [2:0] vecs = '0;

    logic busy4, done4, busy1, done1;
    logic [3:0]  lv4, lz4;
    logic [19:0] lrd4, lr14, lr24;
    logic [0:0]  lv1, lz1;
    logic [4:0]  lrd1, lr11, lr21;

    int checks = 0;
    int fails = 0;

    int  ex_e [16];
    bit  ex_z [16];
    int  ex_n;
    logic [4:0] c_rdb, c_r1b, c_r2b;
    logic [2:0] c_vecs;

    always #2.5 clk = ~clk;

    pes_top #(.XLEN(16), .LANES(4), .RW(5)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred_word(pred),
        .pred_inv(inv), .zero_en(zm), .rd_base(rdb), .rs1_base(r1b), .rs2_base(r2b),
        .rd_is_vec(vecs[0]), .rs1_is_vec(vecs[1]), .rs2_is_vec(vecs[2]),
        .busy(busy4), .done(done4), .lane_valid(lv4), .lane_zero(lz4),
        .lane_rd(lrd4), .lane_rs1(lr14), .lane_rs2(lr24)
    );

    pes_top #(.XLEN(16), .LANES(1), .RW(5)) uut_one (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred_word(pred),
        .pred_inv(inv), .zero_en(zm), .rd_base(rdb), .rs1_base(r1b), .rs2_base(r2b),
        .rd_is_vec(vecs[0]), .rs1_is_vec(vecs[1]), .rs2_is_vec(vecs[2]),
        .busy(busy1), .done(done1), .lane_valid(lv1), .lane_zero(lz1),
        .lane_rd(lrd1), .lane_rs1(lr11), .lane_rs2(lr21)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected issued elements, computed from R2/R3/R5/R7
    task automatic build_expect(input vec_t v);
        int lim;
        lim  = (v.vl > 16) ? 16 : int'(v.vl);
        ex_n = 0;
        for (int e = 0; e < lim; e++) begin
            bit b;
            b = v.mask[e] ^ v.inv;
            if (v.zm) begin
                ex_e[ex_n] = e; ex_z[ex_n] = !b; ex_n++;
            end else if (b) begin
                ex_e[ex_n] = e; ex_z[ex_n] = 1'b0; ex_n++;
            end
        end
        c_rdb = v.rdb; c_r1b = v.r1b; c_r2b = v.r2b; c_vecs = v.vecs;
    endtask

    function automatic logic [4:0] map_reg(input logic [4:0] b, input bit isv, input int e);
        return isv ? 5'(int'(b) + e) : b;
    endfunction

    // one issue cycle of one instance: R3/R5/R6 lane content, R4 done
    task automatic check_group(input int L, input int ptr, input logic bsy, input logic dn,
                               input logic [3:0] lv, input logic [3:0] lz,
                               input logic [19:0] rd, input logic [19:0] r1,
                               input logic [19:0] r2, input string req);
        logic [3:0] e_lv, e_lz;
        logic [19:0] e_rd, e_r1, e_r2, m;
        logic e_dn;
        e_lv = '0; e_lz = '0; e_rd = '0; e_r1 = '0; e_r2 = '0; m = '0;
        for (int k = 0; k < L; k++) begin
            if (ptr + k < ex_n) begin
                e_lv[k] = 1'b1;
                e_lz[k] = ex_z[ptr + k];
                e_rd[k*5 +: 5] = map_reg(c_rdb, c_vecs[0], ex_e[ptr + k]);
                e_r1[k*5 +: 5] = map_reg(c_r1b, c_vecs[1], ex_e[ptr + k]);
                e_r2[k*5 +: 5] = map_reg(c_r2b, c_vecs[2], ex_e[ptr + k]);
                m[k*5 +: 5] = 5'h1F;
            end
        end
        e_dn = (ptr + L >= ex_n);
        check({bsy, dn, lv, lz, rd & m, r1 & m, r2 & m} == {1'b1, e_dn, e_lv, e_lz, e_rd, e_r1, e_r2},
              req, $sformatf("L%0d group at %0d", L, ptr),
              {bsy, dn, lv, lz, rd & m, r1 & m, r2 & m},
              {1'b1, e_dn, e_lv, e_lz, e_rd, e_r1, e_r2});
    endtask

    task automatic run_op(input vec_t v, input bit poke, input string req);
        int ptr4, ptr1, c, d4, d1;
        bit fin4, fin1;
        build_expect(v);
        @(negedge clk);
        vl = v.vl; pred = v.mask; inv = v.inv; zm = v.zm;
        rdb = v.rdb; r1b = v.r1b; r2b = v.r2b; vecs = v.vecs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ptr4 = 0; ptr1 = 0; fin4 = 0; fin1 = 0; c = 0; d4 = 0; d1 = 0;
        while (!(fin4 && fin1) && c < 40) begin
            c++;
            if (!fin4) begin
                check_group(4, ptr4, busy4, done4, lv4, lz4, lrd4, lr14, lr24, req);
                ptr4 += 4;
                if (ptr4 >= ex_n) begin fin4 = 1; d4 = c; end
            end else begin
                check(!busy4 && lv4 == '0, "R9", "L4 idle after done", {busy4, lv4}, 5'h0);
            end
            if (!fin1) begin
                check_group(1, ptr1, busy1, done1, {3'b0, lv1}, {3'b0, lz1},
                            {15'b0, lrd1}, {15'b0, lr11}, {15'b0, lr21}, req);
                ptr1 += 1;
                if (ptr1 >= ex_n) begin fin1 = 1; d1 = c; end
            end else begin
                check(!busy1 && lv1 == '0, "R9", "L1 idle after done", {busy1, lv1}, 2'h0);
            end
            if (poke && c == 1) begin
                // start while busy must be ignored (R9)
                vl = 5'd16; pred = 16'hFFFF; zm = 1'b1; rdb = 5'd9; start = 1'b1;
            end else if (poke && c == 2) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        check(d4 == int'(v.cyc4), "R4", "L4 issue cycles", 64'(d4), 64'(v.cyc4));
        check(d1 == ((ex_n == 0) ? 1 : ex_n), "R4", "L1 issue cycles", 64'(d1),
              64'((ex_n == 0) ? 1 : ex_n));
        check(!busy4 && !busy1, "R9", "busy cleared after done", {busy4, busy1}, 2'b00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!busy4 && !done4 && lv4 == '0, "R10", "L4 reset", {busy4, done4, lv4}, 6'h0);
        check(!busy1 && !done1 && lv1 == '0, "R10", "L1 reset", {busy1, done1, lv1}, 3'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table: R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            run_op(TABLE[i], 1'b0, "R3/R5/R6");
        end

        // directed: R9 start during busy ignored (same op as table entry 0)
        run_op(TABLE[0], 1'b1, "R9");

        // directed: R8 zero length in zeroing mode
        run_op('{5'd0, 16'h0000, 1'b0, 1'b1, 5'd3, 5'd3, 5'd3, 3'b111, 4'd1}, 1'b0, "R8");

        // directed: R1 busy seen in first cycle after start
        @(negedge clk);
        vl = 5'd2; pred = 16'h0003; inv = 1'b0; zm = 1'b0; vecs = 3'b111; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy4 && busy1, "R1", "busy after start", {busy4, busy1}, 2'b11);
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule